// File: doc/BRIEF.md
# One-Wire Bus Passive Monitor

This block listens to a single-wire, open-drain, time-slotted serial bus without ever driving it. It receives a copy of the bus line sampled by the system clock, brings it through a synchroniser, and times every low pulse against a time base `T` (nominally 30 µs), given as a number of clocks per half `T`. From the pulse timing it recovers data bits, recognises bus reset pulses, and samples the slave's presence answer that follows a reset.

A small command layer sits above the slot decoder. After each bus reset it collects the next eight data bits, least significant bit first, into a command byte. It tags that byte with a class code for the standard ROM-level commands, or with an "unknown" code. Everything the block sees is reported as one-cycle strobes that carry their values alongside.

These strobes have no ready input. A passive observer cannot hold the bus still, so every result appears for exactly one cycle and a consumer that needs the value must take it in that cycle. Control is limited to clock and reset.

Top module: `ow_bus_monitor`

## Requirements
- R1: The bus line passes through a two-flop synchroniser whose flops reset to the idle-high level. After reset no strobe is asserted until the bus shows activity.
- R2: The line read low while the monitor is idle marks the start of a slot. The line is sampled `2·HALF_T_CLKS` clocks (one `T`) after that point and reported as `bit_evt` with the level on `bit_val`.
- R3: A sampled 1 returns the monitor at once to idle. A sampled 0 makes it wait for the line to go high before the next slot can start.
- R4: When the line goes high after a sampled 0, `rst_evt` fires if the time since the slot start is more than `16·HALF_T_CLKS` clocks (8·T). A shorter low pulse ends as an ordinary slot and fires no reset.
- R5: `HALF_T_CLKS·5` clocks (2.5·T) after the rising edge that ended a reset, the line is sampled once and reported as `pres_evt`. `pres_found` is 1 when the line was low, meaning a device answered.
- R6: If the presence sample was low, the monitor waits for the line to return high and then goes idle. It issues no second reset, however long the presence pulse lasts.
- R7: Before the first bus reset after block reset, data bits are reported but no command byte is assembled.
- R8: After a bus reset, the next eight data bits are shifted in least significant bit first. `cmd_valid` pulses for one cycle, one clock after the eighth `bit_evt`, with the byte on `cmd_byte`.
- R9: `cmd_kind` codes: 0 read ROM (0x33 or 0x0F), 1 skip ROM (0xCC), 2 match ROM (0x55), 3 search ROM (0xF0), 4 overdrive skip (0x3C), 5 overdrive match (0x69), 7 any other byte.
- R10: Only the first byte after a bus reset is a command. Later data bits produce no `cmd_valid` until the next bus reset.
- R11: A bus reset in the middle of a byte discards the partial command. The count starts again from zero.
- R12: `rst_evt`, `pres_evt` and `bit_evt` are single-cycle and never asserted together. `cmd_valid` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_line | input | 1 | Sampled level of the bus wire (1 = released) |
| rst_evt | output | 1 | Bus reset seen (one cycle) |
| pres_evt | output | 1 | Presence sample taken (one cycle) |
| pres_found | output | 1 | Presence sample was low, valid with `pres_evt` |
| bit_evt | output | 1 | Data bit sampled (one cycle) |
| bit_val | output | 1 | Sampled data bit, valid with `bit_evt` |
| cmd_valid | output | 1 | Command byte complete (one cycle) |
| cmd_byte | output | 8 | Assembled command byte |
| cmd_kind | output | 3 | Command class code, see R9 |

## Verification
Three things are hard to reach from the ports. The first is a presence answer that stays low longer than a reset pulse, where the monitor must not raise a second reset. The second is a reset pulse that lands partway through a command byte. The third is a low pulse a few clocks either side of the 8·T threshold. The stimulus builds each one directly as a sequence of timed low and high spans on `bus_line`. The scoreboard predicts the full event stream for it, including the zero data bit that every reset pulse also produces at its one-`T` sample point. Any event that is missing, extra or early then shows up as a mismatch in order.

// File: rtl/ow_mon_pkg.sv
package ow_mon_pkg;

  typedef enum logic [2:0] {
    LK_IDLE      = 3'd0,
    LK_SAMPLE    = 3'd1,
    LK_WAIT_HIGH = 3'd2,
    LK_PRES      = 3'd3,
    LK_PRES_END  = 3'd4
  } link_state_e;

  typedef enum logic [1:0] {
    NW_OFF     = 2'd0,
    NW_COLLECT = 2'd1,
    NW_DONE    = 2'd2
  } net_state_e;

  typedef enum logic [2:0] {
    CK_READ     = 3'd0,
    CK_SKIP     = 3'd1,
    CK_MATCH    = 3'd2,
    CK_SEARCH   = 3'd3,
    CK_OD_SKIP  = 3'd4,
    CK_OD_MATCH = 3'd5,
    CK_UNKNOWN  = 3'd7
  } cmd_kind_e;

  function automatic cmd_kind_e classify_cmd(input logic [7:0] b);
    cmd_kind_e k;
    case (b)
      8'h33, 8'h0F: k = CK_READ;
      8'hCC:        k = CK_SKIP;
      8'h55:        k = CK_MATCH;
      8'hF0:        k = CK_SEARCH;
      8'h3C:        k = CK_OD_SKIP;
      8'h69:        k = CK_OD_MATCH;
      default:      k = CK_UNKNOWN;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ow_halft_timer.sv
module ow_halft_timer #(
  parameter int HALF_T_CLKS = 15,
  parameter int RST_HALVES  = 16,
  parameter int HCNT_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  output logic [HCNT_W-1:0] hcnt,
  output logic              over_rst
);
  localparam int PCNT_W = (HALF_T_CLKS > 1) ? $clog2(HALF_T_CLKS) : 1;
  localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(HALF_T_CLKS - 1);
  localparam logic [HCNT_W-1:0] HCNT_SAT  = '1;
  localparam logic [HCNT_W-1:0] HCNT_RST  = HCNT_W'(RST_HALVES);

  logic [PCNT_W-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      hcnt <= '0;
    end else if (restart) begin
      pcnt <= '0;
      hcnt <= '0;
    end else if (pcnt == PCNT_LAST) begin
      pcnt <= '0;
      if (hcnt != HCNT_SAT) hcnt <= hcnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  // elapsed clocks = hcnt*HALF_T_CLKS + pcnt; true when strictly past 8T
  assign over_rst = (hcnt > HCNT_RST) || ((hcnt == HCNT_RST) && (pcnt != '0));

  p_restart_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (hcnt == '0));

  p_hcnt_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (hcnt >= $past(hcnt)));
endmodule

// File: rtl/ow_link_fsm.sv
module ow_link_fsm
  import ow_mon_pkg::*;
#(
  parameter int SAMPLE_HALVES = 2,
  parameter int PRES_HALVES   = 5,
  parameter int HCNT_W        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_s,
  input  logic [HCNT_W-1:0] hcnt,
  input  logic              over_rst,
  output logic              restart,
  output logic              rst_evt,
  output logic              pres_evt,
  output logic              pres_found,
  output logic              bit_evt,
  output logic              bit_val
);
  localparam logic [HCNT_W-1:0] HC_SAMPLE = HCNT_W'(SAMPLE_HALVES);
  localparam logic [HCNT_W-1:0] HC_PRES   = HCNT_W'(PRES_HALVES);

  link_state_e state, state_nx;
  logic take_bit, take_pres, saw_reset;

  always_comb begin
    state_nx  = state;
    restart   = 1'b0;
    take_bit  = 1'b0;
    take_pres = 1'b0;
    saw_reset = 1'b0;
    case (state)
      LK_IDLE: begin
        if (!line_s) begin
          restart  = 1'b1;
          state_nx = LK_SAMPLE;
        end
      end
      LK_SAMPLE: begin
        if (hcnt == HC_SAMPLE) begin
          take_bit = 1'b1;
          state_nx = line_s ? LK_IDLE : LK_WAIT_HIGH;
        end
      end
      LK_WAIT_HIGH: begin
        if (line_s) begin
          if (over_rst) begin
            saw_reset = 1'b1;
            restart   = 1'b1;
            state_nx  = LK_PRES;
          end else begin
            state_nx  = LK_IDLE;
          end
        end
      end
      LK_PRES: begin
        if (hcnt == HC_PRES) begin
          take_pres = 1'b1;
          state_nx  = line_s ? LK_IDLE : LK_PRES_END;
        end
      end
      LK_PRES_END: begin
        if (line_s) state_nx = LK_IDLE;
      end
      default: state_nx = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= LK_IDLE;
      rst_evt    <= 1'b0;
      pres_evt   <= 1'b0;
      pres_found <= 1'b0;
      bit_evt    <= 1'b0;
      bit_val    <= 1'b0;
    end else begin
      state    <= state_nx;
      rst_evt  <= saw_reset;
      pres_evt <= take_pres;
      bit_evt  <= take_bit;
      if (take_pres) pres_found <= ~line_s;
      if (take_bit)  bit_val    <= line_s;
    end
  end

  p_link_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rst_evt, pres_evt, bit_evt}) <= 1);

  p_reset_needs_long_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |-> $past(over_rst));

  p_reset_then_presence_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |-> (state == LK_PRES));

  p_bit_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bit_evt |=> !bit_evt);

  p_pres_end_no_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == LK_PRES_END) |-> !rst_evt);
endmodule

// File: rtl/ow_cmd_layer.sv
module ow_cmd_layer
  import ow_mon_pkg::*;
#(
  parameter int CMD_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_reset,
  input  logic                bit_evt,
  input  logic                bit_val,
  output logic                cmd_valid,
  output logic [CMD_BITS-1:0] cmd_byte,
  output logic [2:0]          cmd_kind
);
  localparam int CNT_W = $clog2(CMD_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CMD_BITS - 1);

  net_state_e          state;
  logic [CNT_W-1:0]    nbits;
  logic [CMD_BITS-1:0] shreg;
  logic [CMD_BITS-1:0] shreg_nx;

  assign shreg_nx = {bit_val, shreg[CMD_BITS-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= NW_OFF;
      nbits     <= '0;
      shreg     <= '0;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
      cmd_kind  <= 3'd0;
    end else begin
      cmd_valid <= 1'b0;
      if (bus_reset) begin
        state <= NW_COLLECT;
        nbits <= '0;
        shreg <= '0;
      end else if (bit_evt && state == NW_COLLECT) begin
        shreg <= shreg_nx;
        if (nbits == LAST_BIT) begin
          state     <= NW_DONE;
          nbits     <= '0;
          cmd_valid <= 1'b1;
          cmd_byte  <= shreg_nx;
          cmd_kind  <= 3'(classify_cmd(8'(shreg_nx)));
        end else begin
          nbits <= nbits + 1'b1;
        end
      end
    end
  end

  p_cmd_follows_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(bit_evt));

  p_cmd_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  p_off_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == NW_OFF) |=> !cmd_valid);

  p_done_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == NW_DONE && !bus_reset) |=> !cmd_valid);
endmodule

// File: rtl/ow_bus_monitor.sv
module ow_bus_monitor #(
  parameter int HALF_T_CLKS   = 15,
  parameter int SYNC_STAGES   = 2,
  parameter int SAMPLE_HALVES = 2,
  parameter int RST_HALVES    = 16,
  parameter int PRES_HALVES   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_line,
  output logic       rst_evt,
  output logic       pres_evt,
  output logic       pres_found,
  output logic       bit_evt,
  output logic       bit_val,
  output logic       cmd_valid,
  output logic [7:0] cmd_byte,
  output logic [2:0] cmd_kind
);
  localparam int HCNT_W = $clog2(RST_HALVES + 2) + 1;

  logic              line_s;
  logic              restart;
  logic              over_rst;
  logic [HCNT_W-1:0] hcnt;

  ow_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .din (bus_line),
    .dout (line_s)
  );

  ow_halft_timer #(
    .HALF_T_CLKS (HALF_T_CLKS),
    .RST_HALVES  (RST_HALVES),
    .HCNT_W      (HCNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .hcnt     (hcnt),
    .over_rst (over_rst)
  );

  ow_link_fsm #(
    .SAMPLE_HALVES (SAMPLE_HALVES),
    .PRES_HALVES   (PRES_HALVES),
    .HCNT_W        (HCNT_W)
  ) u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_s     (line_s),
    .hcnt       (hcnt),
    .over_rst   (over_rst),
    .restart    (restart),
    .rst_evt    (rst_evt),
    .pres_evt   (pres_evt),
    .pres_found (pres_found),
    .bit_evt    (bit_evt),
    .bit_val    (bit_val)
  );

  ow_cmd_layer #(.CMD_BITS(8)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (rst_evt),
    .bit_evt   (bit_evt),
    .bit_val   (bit_val),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .cmd_kind  (cmd_kind)
  );
endmodule

// File: tb/ow_bus_monitor_test.sv
module ow_bus_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 5;
  localparam int LIMIT = 16 * HALF;

  localparam int EV_BIT  = 0;
  localparam int EV_RST  = 1;
  localparam int EV_PRES = 2;
  localparam int EV_CMD  = 3;

  typedef struct {
    int    kind;
    int    val;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_line = 1'b1;
  logic rst_evt, pres_evt, pres_found, bit_evt, bit_val, cmd_valid;
  logic [7:0] cmd_byte;
  logic [2:0] cmd_kind;

  int checks = 0;
  int errors = 0;
  bit monitor_on = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ow_bus_monitor #(.HALF_T_CLKS(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .bus_line(bus_line),
    .rst_evt(rst_evt), .pres_evt(pres_evt), .pres_found(pres_found),
    .bit_evt(bit_evt), .bit_val(bit_val),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_kind(cmd_kind)
  );

  function automatic void push(int kind, int val, string req);
    exp_t e;
    e.kind = kind; e.val = val; e.req = req;
    sb.push_back(e);
  endfunction

  task automatic take(int kind, int val);
    exp_t e;
    checks++;
    if (sb.size() == 0) begin
      errors++;
      $display("FAIL R12 unexpected event kind=%0d val=%0h expected none", kind, val);
    end else begin
      e = sb.pop_front();
      if (e.kind != kind || e.val != val) begin
        errors++;
        $display("FAIL %s event kind=%0d val=%0h expected kind=%0d val=%0h",
                 e.req, kind, val, e.kind, e.val);
      end
    end
  endtask

  // monitor: compares strobes against the scoreboard
  always @(negedge clk) begin
    if (monitor_on) begin
      if (bit_evt)   take(EV_BIT, int'(bit_val));
      if (rst_evt)   take(EV_RST, 0);
      if (pres_evt)  take(EV_PRES, int'(pres_found));
      if (cmd_valid) take(EV_CMD, int'({cmd_kind, cmd_byte}));
    end
  end

  task automatic hold(logic lvl, int n);
    bus_line = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic slot(logic b, string req);
    push(EV_BIT, int'(b), req);
    if (b) begin hold(1'b0, 3);  hold(1'b1, 40); end
    else   begin hold(1'b0, 25); hold(1'b1, 25); end
  endtask

  task automatic send_byte(logic [7:0] v, bit cmd_expected, int kind, string req);
    for (int i = 0; i < 8; i++) begin
      if (cmd_expected && i == 7) begin
        push(EV_BIT, int'(v[i]), req);
        push(EV_CMD, int'({3'(kind), v}), req);
        if (v[i]) begin hold(1'b0, 3);  hold(1'b1, 40); end
        else      begin hold(1'b0, 25); hold(1'b1, 25); end
      end else begin
        slot(v[i], req);
      end
    end
  endtask

  task automatic bus_reset(bit present, int pres_len, string req);
    push(EV_BIT, 0, "R2");
    push(EV_RST, 0, "R4");
    push(EV_PRES, int'(present), req);
    hold(1'b0, LIMIT + 20);
    if (present) begin
      hold(1'b1, 8);
      hold(1'b0, pres_len);
      hold(1'b1, 40);
    end else begin
      hold(1'b1, 60);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    checks++;
    if ({rst_evt, pres_evt, bit_evt, cmd_valid} != 4'b0) begin
      errors++;
      $display("FAIL R1 strobes during reset = %b expected 0000",
               {rst_evt, pres_evt, bit_evt, cmd_valid});
    end
    rst_n = 1'b1;
    monitor_on = 1'b1;
    repeat (10) @(negedge clk);
    checks++;
    if ({rst_evt, pres_evt, bit_evt, cmd_valid} != 4'b0) begin
      errors++;
      $display("FAIL R1 strobes while idle = %b expected 0000",
               {rst_evt, pres_evt, bit_evt, cmd_valid});
    end

    // R7: bits before any bus reset give no command
    send_byte(8'hCC, 1'b0, 0, "R7");

    // R5 presence answered, R8/R9 skip ROM, LSB first
    bus_reset(1'b1, 40, "R5");
    send_byte(8'hCC, 1'b1, 1, "R8");

    // R10: following byte is not a command
    send_byte(8'h55, 1'b0, 0, "R10");

    // R5 no presence, R9 read ROM variants
    bus_reset(1'b0, 0, "R5");
    send_byte(8'h33, 1'b1, 0, "R9");
    bus_reset(1'b1, 40, "R5");
    send_byte(8'h0F, 1'b1, 0, "R9");
    bus_reset(1'b1, 40, "R5");
    send_byte(8'h55, 1'b1, 2, "R9");
    bus_reset(1'b1, 40, "R5");
    send_byte(8'hF0, 1'b1, 3, "R9");
    bus_reset(1'b1, 40, "R5");
    send_byte(8'h3C, 1'b1, 4, "R9");
    bus_reset(1'b1, 40, "R5");
    send_byte(8'h69, 1'b1, 5, "R9");
    bus_reset(1'b1, 40, "R5");
    send_byte(8'hA5, 1'b1, 7, "R9");

    // R4: low just below the limit is a slot, just above is a reset
    push(EV_BIT, 0, "R4");
    hold(1'b0, LIMIT - 4);
    hold(1'b1, 30);
    push(EV_BIT, 0, "R4");
    push(EV_RST, 0, "R4");
    push(EV_PRES, 0, "R4");
    hold(1'b0, LIMIT + 4);
    hold(1'b1, 60);
    send_byte(8'h0F, 1'b1, 0, "R4");

    // R11: reset partway through a byte
    bus_reset(1'b1, 40, "R5");
    slot(1'b1, "R11");
    slot(1'b0, "R11");
    slot(1'b1, "R11");
    bus_reset(1'b1, 40, "R11");
    send_byte(8'h69, 1'b1, 5, "R11");

    // R6: presence held low beyond 8T raises no second reset
    bus_reset(1'b1, LIMIT + 40, "R6");
    send_byte(8'hF0, 1'b1, 3, "R6");

    // R3: back-to-back ones with short recovery still decode
    bus_reset(1'b1, 40, "R3");
    send_byte(8'hFF, 1'b1, 7, "R3");

    repeat (20) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R12 missing events count=%0d expected 0", sb.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule